// File: doc/BRIEF.md
# SPI Command Frame Decoder for a Quad Digital Potentiometer

This block is the serial front end of a controller for four digital potentiometers. It watches an SPI mode-0 link in which the host clocks data in on the rising edge of SCK while chip select is held low. The first byte of a frame must carry a fixed device-type nibble, two zero bits and a two-bit device address that matches the strapped `addr_pins`. If it does not match, the rest of the frame is dropped. The second byte gives an opcode, a register index and a pot index. From the opcode the block decides whether the command ends after that byte, takes a third byte, or opens an unbounded stepping phase.

The SPI pins are oversampled in the system clock domain through a short synchronizer. The block sends single-cycle strobes to the register blocks that sit next to it. `cmd_stb` carries the opcode, register, pot and, for writes, the data byte. `step_stb` and `step_up` carry wiper steps. For read commands the neighbouring register block supplies `rd_data`. The decoder captures it and shifts it out MSB first on `so`. The pad enable `so_oe` is raised only while read data is on the line.

Top module: `spi_pot_cmd_decoder`

## Requirements
- R1: A frame's first byte is accepted only when bits 7:4 equal 4'b0101, bits 3:2 are 0 and bits 1:0 equal `addr_pins`. Otherwise no strobe of any kind is produced until `cs_n` goes high.
- R2: When a recognised opcode arrives in the second byte, `cmd_op` takes bits 7:4, `cmd_reg` takes bits 3:2 and `cmd_pot` takes bits 1:0. These values hold until the next recognised command.
- R3: Opcodes 0xD (data register to wiper), 0xE (wiper to data register), 0x1 (global data register to wiper) and 0x2 (global wiper to data register) end at the 16th bit. They produce exactly one `cmd_stb`, and any later bits in the same frame are ignored.
- R4: Opcodes 0xA (write wiper) and 0xC (write data register) produce exactly one `cmd_stb` after the 24th bit. `cmd_data` then holds the third byte, which is received MSB first.
- R5: Opcodes 0x8 (read wiper), 0xB (read data register) and 0x5 (read status) produce one `cmd_stb` after the 16th bit. `rd_data` is captured one clock later. It is then driven on `so` MSB first, and `so` changes only after a falling SCK edge, so each bit is valid before the next rising edge.
- R6: `so_oe` is 1 only during the third byte of a read command. It is 0 during the header bytes, after the 24th bit, when `cs_n` is high, and for all other commands.
- R7: Opcode 0x3 starts a stepping phase that produces no `cmd_stb`. Every later rising SCK edge in the frame gives one `step_stb`, with `step_up` equal to SI.
- R8: Any opcode outside the ten listed produces no `cmd_stb` and no `step_stb` for the rest of the frame.
- R9: Raising `cs_n` at any bit position clears the frame, and the next frame starts again with an identification byte.
- R10: `cmd_stb` and `step_stb` last one clock each and are never high together.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the SPI pins |
| rst | input | 1 | Synchronous active-high reset |
| sck | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| addr_pins | input | 2 | Strapped device address |
| rd_data | input | DATA_W | Byte returned by the register blocks for a read command |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for the SO pad driver |
| cmd_stb | output | 1 | One-cycle command strobe |
| cmd_op | output | 4 | Latched opcode |
| cmd_reg | output | 2 | Latched register index |
| cmd_pot | output | 2 | Latched pot index |
| cmd_data | output | DATA_W | Data byte of a write command |
| step_stb | output | 1 | One-cycle wiper step strobe |
| step_up | output | 1 | Step direction, 1 toward the high end |

## Verification
The bench builds the decoder with its default parameters: a two-stage synchronizer, an 8-bit data byte and a type nibble of 0101. SCK runs at one sixteenth of the system clock. With 2-bit addresses and a 4-bit opcode field, every identification byte with the right type nibble can be swept against every address strap, and all sixteen opcodes can be sent as full three-byte frames. Read bytes come from an arithmetic stand-in for the register blocks, and step counts are predicted from the population count of the SI pattern. A frame aborted in mid-instruction and a long stepping frame cover the cases left at the edges.

// File: rtl/pot_cmd_pkg.sv
package pot_cmd_pkg;

  localparam logic [3:0] OP_RD_WCR  = 4'h8;
  localparam logic [3:0] OP_WR_WCR  = 4'hA;
  localparam logic [3:0] OP_RD_DR   = 4'hB;
  localparam logic [3:0] OP_WR_DR   = 4'hC;
  localparam logic [3:0] OP_LD_WCR  = 4'hD;
  localparam logic [3:0] OP_ST_DR   = 4'hE;
  localparam logic [3:0] OP_GLD_WCR = 4'h1;
  localparam logic [3:0] OP_GST_DR  = 4'h2;
  localparam logic [3:0] OP_RD_STAT = 4'h5;
  localparam logic [3:0] OP_STEP    = 4'h3;

  typedef enum logic [2:0] {
    ST_ID, ST_INS, ST_RD, ST_WR, ST_STEP, ST_DONE, ST_IGN
  } frame_st_t;

  typedef enum logic [2:0] {
    K_NONE, K_XFER, K_READ, K_WRITE, K_STEP
  } cmd_kind_t;

  function automatic cmd_kind_t op_kind(input logic [3:0] op);
    case (op)
      OP_RD_WCR, OP_RD_DR, OP_RD_STAT:              return K_READ;
      OP_WR_WCR, OP_WR_DR:                          return K_WRITE;
      OP_LD_WCR, OP_ST_DR, OP_GLD_WCR, OP_GST_DR:   return K_XFER;
      OP_STEP:                                      return K_STEP;
      default:                                      return K_NONE;
    endcase
  endfunction

  function automatic logic is_read_op(input logic [3:0] op);
    return (op == OP_RD_WCR) || (op == OP_RD_DR) || (op == OP_RD_STAT);
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck,
  input  logic cs_n,
  input  logic si,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel,
  output logic si_s
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sck_pipe;
  logic [LAST:0] cs_pipe;
  logic [LAST:0] si_pipe;
  logic          sck_last;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          sck_pipe <= '0;
          cs_pipe  <= '1;
          si_pipe  <= '0;
        end else begin
          sck_pipe <= sck;
          cs_pipe  <= cs_n;
          si_pipe  <= si;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) begin
          sck_pipe <= '0;
          cs_pipe  <= '1;
          si_pipe  <= '0;
        end else begin
          sck_pipe <= {sck_pipe[LAST-1:0], sck};
          cs_pipe  <= {cs_pipe[LAST-1:0], cs_n};
          si_pipe  <= {si_pipe[LAST-1:0], si};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) sck_last <= 1'b0;
    else     sck_last <= sck_pipe[LAST];
  end

  assign sck_rise = sck_pipe[LAST] & ~sck_last;
  assign sck_fall = ~sck_pipe[LAST] & sck_last;
  assign sel      = ~cs_pipe[LAST];
  assign si_s     = si_pipe[LAST];

endmodule

// File: rtl/spi_frame_ctrl.sv
module spi_frame_ctrl
  import pot_cmd_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter logic [3:0]  TYPE_ID = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              sck_rise,
  input  logic              si,
  input  logic [1:0]        addr_pins,
  output logic              cmd_stb,
  output logic [3:0]        cmd_op,
  output logic [1:0]        cmd_reg,
  output logic [1:0]        cmd_pot,
  output logic [DATA_W-1:0] cmd_data,
  output logic              step_stb,
  output logic              step_up,
  output logic              rd_active,
  output logic              rd_load
);
  localparam int HDR_W = 8;
  localparam int CNT_W = $clog2(DATA_W > HDR_W ? DATA_W : HDR_W);

  frame_st_t          st;
  cmd_kind_t          kind_q;
  logic [CNT_W-1:0]   bit_cnt;
  logic [DATA_W-1:0]  shreg;

  logic [HDR_W-1:0]   byte_now;
  logic [DATA_W-1:0]  data_now;
  logic               hdr_last;
  logic               data_last;
  logic               id_ok;
  cmd_kind_t          kind_now;

  assign byte_now  = {shreg[HDR_W-2:0], si};
  assign data_now  = {shreg[DATA_W-2:0], si};
  assign hdr_last  = (bit_cnt == CNT_W'(HDR_W - 1));
  assign data_last = (bit_cnt == CNT_W'(DATA_W - 1));
  assign id_ok     = (byte_now[7:4] == TYPE_ID) && (byte_now[3:2] == 2'b00)
                     && (byte_now[1:0] == addr_pins);
  assign kind_now  = op_kind(byte_now[7:4]);
  assign rd_active = (st == ST_RD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_ID;
      kind_q   <= K_NONE;
      bit_cnt  <= '0;
      shreg    <= '0;
      cmd_stb  <= 1'b0;
      cmd_op   <= '0;
      cmd_reg  <= '0;
      cmd_pot  <= '0;
      cmd_data <= '0;
      step_stb <= 1'b0;
      step_up  <= 1'b0;
      rd_load  <= 1'b0;
    end else begin
      cmd_stb  <= 1'b0;
      step_stb <= 1'b0;
      rd_load  <= cmd_stb && (kind_q == K_READ);
      if (!sel) begin
        st      <= ST_ID;
        bit_cnt <= '0;
        shreg   <= '0;
      end else if (sck_rise) begin
        case (st)
          ST_ID: begin
            shreg   <= data_now;
            bit_cnt <= bit_cnt + 1'b1;
            if (hdr_last) begin
              bit_cnt <= '0;
              st      <= id_ok ? ST_INS : ST_IGN;
            end
          end
          ST_INS: begin
            shreg   <= data_now;
            bit_cnt <= bit_cnt + 1'b1;
            if (hdr_last) begin
              bit_cnt <= '0;
              kind_q  <= kind_now;
              if (kind_now != K_NONE) begin
                cmd_op  <= byte_now[7:4];
                cmd_reg <= byte_now[3:2];
                cmd_pot <= byte_now[1:0];
              end
              case (kind_now)
                K_XFER:  begin cmd_stb <= 1'b1; st <= ST_DONE; end
                K_READ:  begin cmd_stb <= 1'b1; st <= ST_RD;   end
                K_WRITE: st <= ST_WR;
                K_STEP:  st <= ST_STEP;
                default: st <= ST_IGN;
              endcase
            end
          end
          ST_WR: begin
            shreg   <= data_now;
            bit_cnt <= bit_cnt + 1'b1;
            if (data_last) begin
              cmd_data <= data_now;
              cmd_stb  <= 1'b1;
              st       <= ST_DONE;
            end
          end
          ST_RD: begin
            bit_cnt <= bit_cnt + 1'b1;
            if (data_last) st <= ST_DONE;
          end
          ST_STEP: begin
            step_stb <= 1'b1;
            step_up  <= si;
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/spi_read_shift.sv
module spi_read_shift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              active,
  input  logic              sck_fall,
  output logic              so,
  output logic              so_oe
);
  logic [DATA_W-1:0] rd_buf;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_buf <= '0;
      so     <= 1'b0;
      so_oe  <= 1'b0;
    end else if (load) begin
      rd_buf <= load_data;
    end else if (!active) begin
      so     <= 1'b0;
      so_oe  <= 1'b0;
    end else if (sck_fall) begin
      so     <= rd_buf[DATA_W-1];
      so_oe  <= 1'b1;
      rd_buf <= {rd_buf[DATA_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/spi_pot_cmd_decoder.sv
module spi_pot_cmd_decoder #(
  parameter int          SYNC_STAGES = 2,
  parameter int          DATA_W      = 8,
  parameter logic [3:0]  TYPE_ID     = 4'b0101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              si,
  input  logic [1:0]        addr_pins,
  input  logic [DATA_W-1:0] rd_data,
  output logic              so,
  output logic              so_oe,
  output logic              cmd_stb,
  output logic [3:0]        cmd_op,
  output logic [1:0]        cmd_reg,
  output logic [1:0]        cmd_pot,
  output logic [DATA_W-1:0] cmd_data,
  output logic              step_stb,
  output logic              step_up
);
  logic sck_rise_w;
  logic sck_fall_w;
  logic sel_w;
  logic si_w;
  logic rd_active_w;
  logic rd_load_w;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .sck      (sck),
    .cs_n     (cs_n),
    .si       (si),
    .sck_rise (sck_rise_w),
    .sck_fall (sck_fall_w),
    .sel      (sel_w),
    .si_s     (si_w)
  );

  spi_frame_ctrl #(.DATA_W(DATA_W), .TYPE_ID(TYPE_ID)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .sel       (sel_w),
    .sck_rise  (sck_rise_w),
    .si        (si_w),
    .addr_pins (addr_pins),
    .cmd_stb   (cmd_stb),
    .cmd_op    (cmd_op),
    .cmd_reg   (cmd_reg),
    .cmd_pot   (cmd_pot),
    .cmd_data  (cmd_data),
    .step_stb  (step_stb),
    .step_up   (step_up),
    .rd_active (rd_active_w),
    .rd_load   (rd_load_w)
  );

  spi_read_shift #(.DATA_W(DATA_W)) u_rdsh (
    .clk       (clk),
    .rst       (rst),
    .load      (rd_load_w),
    .load_data (rd_data),
    .active    (rd_active_w),
    .sck_fall  (sck_fall_w),
    .so        (so),
    .so_oe     (so_oe)
  );

endmodule

// File: rtl/spi_pot_cmd_checker.sv
module spi_pot_cmd_checker
  import pot_cmd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cmd_stb,
  input logic [3:0] cmd_op,
  input logic       step_stb,
  input logic       so_oe,
  input logic       sck_fall,
  input logic       rd_active
);

  assert_stb_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_stb |=> !cmd_stb);

  assert_stb_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(cmd_stb && step_stb));

  assert_step_opcode_R7: assert property (@(posedge clk) disable iff (rst)
    step_stb |-> (cmd_op == OP_STEP));

  assert_oe_read_only_R6: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> is_read_op(cmd_op));

  assert_oe_in_phase_R6: assert property (@(posedge clk) disable iff (rst)
    so_oe |-> $past(rd_active));

  assert_oe_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(so_oe) |-> $past(sck_fall));

endmodule

bind spi_pot_cmd_decoder spi_pot_cmd_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_stb   (cmd_stb),
  .cmd_op    (cmd_op),
  .step_stb  (step_stb),
  .so_oe     (so_oe),
  .sck_fall  (sck_fall_w),
  .rd_active (rd_active_w)
);

// File: tb/sim_spi_pot_cmd_decoder.sv
`timescale 1ns/1ps
module sim_spi_pot_cmd_decoder;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sck = 1'b0;
  logic       cs_n = 1'b1;
  logic       si = 1'b0;
  logic [1:0] addr_pins = 2'd0;
  logic [7:0] rd_data;
  logic       so, so_oe, cmd_stb, step_stb, step_up;
  logic [3:0] cmd_op;
  logic [1:0] cmd_reg, cmd_pot;
  logic [7:0] cmd_data;

  int n_chk = 0;
  int n_fail = 0;
  int stb_tot = 0, up_tot = 0, dn_tot = 0;
  int stb_d, up_d, dn_d;
  logic [7:0] rd_got;
  bit oe_hdr, oe_any3, oe_all3;

  always #2.5 clk = ~clk;

  // stand-in register block: returned byte is a function of the latched fields
  assign rd_data = {cmd_op, cmd_reg, cmd_pot} ^ 8'h5A;

  spi_pot_cmd_decoder u0 (
    .clk(clk), .rst(rst), .sck(sck), .cs_n(cs_n), .si(si),
    .addr_pins(addr_pins), .rd_data(rd_data), .so(so), .so_oe(so_oe),
    .cmd_stb(cmd_stb), .cmd_op(cmd_op), .cmd_reg(cmd_reg), .cmd_pot(cmd_pot),
    .cmd_data(cmd_data), .step_stb(step_stb), .step_up(step_up)
  );

  always @(negedge clk) begin
    if (cmd_stb) stb_tot++;
    if (step_stb) begin
      if (step_up) up_tot++;
      else dn_tot++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic clk_wait(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, output logic so_s, output logic oe_s);
    si = b;
    clk_wait(HALF);
    so_s = so;
    oe_s = so_oe;
    sck = 1'b1;
    clk_wait(HALF);
    sck = 1'b0;
  endtask

  task automatic frame(input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input int nbytes);
    int s0, u0c, d0c;
    logic [7:0] bytes [3];
    logic so_s, oe_s;
    bytes[0] = b0; bytes[1] = b1; bytes[2] = b2;
    s0 = stb_tot; u0c = up_tot; d0c = dn_tot;
    oe_hdr = 0; oe_any3 = 0; oe_all3 = 1; rd_got = 8'h00;
    cs_n = 1'b0;
    clk_wait(4);
    for (int k = 0; k < nbytes; k++) begin
      for (int b = 7; b >= 0; b--) begin
        send_bit(bytes[k][b], so_s, oe_s);
        if (k < 2) oe_hdr |= oe_s;
        else begin
          oe_any3 |= oe_s;
          oe_all3 &= oe_s;
          rd_got = {rd_got[6:0], so_s};
        end
      end
    end
    clk_wait(4);
    cs_n = 1'b1;
    clk_wait(10);
    stb_d = stb_tot - s0; up_d = up_tot - u0c; dn_d = dn_tot - d0c;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic so_s, oe_s;
    clk_wait(5);
    rst = 1'b0;
    clk_wait(2);
    // R11 reset state
    check({so, so_oe, cmd_stb, cmd_op, cmd_reg, cmd_pot, cmd_data, step_stb, step_up} == '0,
          "R11", "outputs after reset", {cmd_op, cmd_data}, 0);

    // R1 identification sweep: every low nibble against every strap, transfer command
    for (int p = 0; p < 4; p++) begin
      addr_pins = 2'(p);
      for (int lo = 0; lo < 16; lo++) begin
        bit match;
        match = (lo == p);
        frame({4'b0101, 4'(lo)}, {4'hD, 4'(lo)}, 8'hFF, 2);
        if (match)
          check(stb_d == 1 && cmd_op == 4'hD && {cmd_reg, cmd_pot} == 4'(lo),
                "R1", "accepted id strobe/fields", {stb_d, cmd_op, cmd_reg, cmd_pot},
                {1, 4'hD, 4'(lo)});
        else
          check(stb_d == 0, "R1", "rejected id strobes", stb_d, 0);
      end
    end

    // R1 wrong type nibble
    addr_pins = 2'd1;
    for (int t = 0; t < 16; t++) begin
      if (t == 5) continue;
      frame({4'(t), 4'b0001}, 8'hA5, 8'h33, 3);
      check(stb_d == 0 && up_d + dn_d == 0, "R1", "wrong type nibble strobes", stb_d, 0);
    end

    // Opcode sweep, full three-byte frames
    addr_pins = 2'd2;
    for (int op = 0; op < 16; op++) begin
      logic [7:0] ins, dat;
      int exp_up;
      ins = {4'(op), 2'(op), ~2'(op)};
      dat = 8'((op * 37 + 11) & 255);
      frame(8'h52, ins, dat, 3);
      check(!oe_hdr, "R6", "so_oe during header", oe_hdr, 0);
      case (op)
        'hD, 'hE, 'h1, 'h2: begin // R3
          check(stb_d == 1, "R3", "transfer strobe count", stb_d, 1);
          check({cmd_op, cmd_reg, cmd_pot} == ins, "R2", "transfer fields",
                {cmd_op, cmd_reg, cmd_pot}, ins);
          check(!oe_any3, "R6", "so_oe on transfer", oe_any3, 0);
        end
        'hA, 'hC: begin // R4
          check(stb_d == 1 && cmd_data == dat, "R4", "write strobe/data",
                {stb_d, cmd_data}, {1, dat});
          check({cmd_op, cmd_reg, cmd_pot} == ins, "R2", "write fields",
                {cmd_op, cmd_reg, cmd_pot}, ins);
          check(!oe_any3, "R6", "so_oe on write", oe_any3, 0);
        end
        'h8, 'hB, 'h5: begin // R5
          check(stb_d == 1, "R5", "read strobe count", stb_d, 1);
          check(rd_got == (ins ^ 8'h5A), "R5", "read byte on so", rd_got, ins ^ 8'h5A);
          check(oe_all3, "R6", "so_oe through read byte", oe_all3, 1);
          check(!so_oe, "R6", "so_oe after frame", so_oe, 0);
        end
        'h3: begin // R7
          exp_up = $countones(dat);
          check(stb_d == 0 && up_d == exp_up && dn_d == 8 - exp_up, "R7",
                "step counts", {stb_d, up_d, dn_d}, {0, exp_up, 8 - exp_up});
          check(cmd_pot == ins[1:0], "R2", "step pot", cmd_pot, ins[1:0]);
        end
        default: begin // R8
          check(stb_d == 0 && up_d == 0 && dn_d == 0, "R8", "unknown opcode activity",
                stb_d + up_d + dn_d, 0);
          check(!oe_any3, "R6", "so_oe on unknown", oe_any3, 0);
        end
      endcase
    end

    // R7 long stepping frame, 40 steps, up when index % 3 == 0
    begin
      int s0, u0c, d0c;
      s0 = stb_tot; u0c = up_tot; d0c = dn_tot;
      cs_n = 1'b0;
      clk_wait(4);
      for (int b = 7; b >= 0; b--) send_bit(8'h52 >> b, so_s, oe_s);
      for (int b = 7; b >= 0; b--) send_bit(8'h36 >> b, so_s, oe_s);
      for (int i = 0; i < 40; i++) send_bit(i % 3 == 0, so_s, oe_s);
      clk_wait(4);
      cs_n = 1'b1;
      clk_wait(10);
      check(up_tot - u0c == 14 && dn_tot - d0c == 26 && stb_tot == s0, "R7",
            "long step run up count", up_tot - u0c, 14);
    end

    // R9 abort mid-instruction, then a clean write frame
    begin
      int s0;
      s0 = stb_tot;
      cs_n = 1'b0;
      clk_wait(4);
      for (int b = 7; b >= 0; b--) send_bit(8'h52 >> b, so_s, oe_s);
      for (int b = 7; b >= 4; b--) send_bit(8'hD0 >> b, so_s, oe_s);
      clk_wait(4);
      cs_n = 1'b1;
      clk_wait(10);
      check(stb_tot == s0, "R9", "strobes from aborted frame", stb_tot - s0, 0);
      frame(8'h52, 8'hC7, 8'h96, 3);
      check(stb_d == 1 && cmd_data == 8'h96 && {cmd_op, cmd_reg, cmd_pot} == 8'hC7,
            "R9", "write after abort", {cmd_op, cmd_reg, cmd_pot, cmd_data}, 16'hC796);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule